// File: doc/BRIEF.md
# Password Retry Lockout Guard

This block decides whether a password-protected storage device may still accept accesses after a run of failed password attempts. It holds three values that are loaded in configuration mode: an 8-bit attempt limit, an 8-bit attempt counter and an 8-bit policy byte. The policy byte selects whether counting is active, whether a correct password clears the counter, and which of two lockout styles applies once the limit is reached.

Before each attempt the block compares the counter with the limit. When counting is active and the two are equal, the lockout is in force. Depending on the policy, the lockout either forbids everything or leaves only configuration operations open. The surrounding protocol logic reports the end of each attempt with a one-cycle strobe, together with the comparison result and the class of the operation. On that strobe the counter advances on a wrong password, or is cleared or kept on a correct one. Arithmetic is modulo 256, so a counter loaded above the limit passes through 255 and 0 before it meets the limit.

Top module: `pw_retry_guard`

## Requirements
- R1: After reset the counter, limit and policy byte all read 0, and both `normal_allowed` and `config_allowed` are 1.
- R2: In the policy byte, bit 7 is lockout-select A, bit 6 is lockout-select B, bit 3 is clear-on-success and bit 2 is count-enable. A write stores those four bits, and the other bits always read back as 0.
- R3: The limit and counter each take any value from 0 to 255 through their write ports, visible on the cycle after the write. A counter write in the same cycle as an attempt strobe wins over the attempt update.
- R4: While count-enable is 0, both allowed flags are 1 whatever the counter and limit hold, and attempt strobes leave the counter unchanged.
- R5: While count-enable is 1 and the counter differs from the limit, both allowed flags are 1.
- R6: While count-enable is 1, the counter equals the limit, and select A,B = 1,0, both allowed flags are 0.
- R7: While count-enable is 1, the counter equals the limit, and select A,B is 0,0, 0,1 or 1,1, `normal_allowed` is 0 and `config_allowed` is 1.
- R8: An attempt strobe with a wrong password, count-enable 1, a permitted operation class and the counter below the lockout point adds 1 to the counter on the next cycle, wrapping from 255 to 0.
- R9: An attempt strobe with a correct password, count-enable 1 and a permitted class clears the counter if clear-on-success is 1, and leaves it unchanged if clear-on-success is 0.
- R10: An attempt of a class that is not currently allowed changes nothing. A permitted configuration attempt made during a configuration-only lockout does not advance the counter on a wrong password.
- R11: Without an attempt strobe or a counter write, the counter holds. Each strobe cycle updates it at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Load the policy byte |
| cfg_wr_data | input | 8 | Policy byte to load |
| lim_wr_en | input | 1 | Load the attempt limit |
| lim_wr_data | input | 8 | Limit value |
| cnt_wr_en | input | 1 | Load the attempt counter |
| cnt_wr_data | input | 8 | Counter value |
| attempt_done | input | 1 | One-cycle strobe marking the end of a password attempt |
| attempt_ok | input | 1 | Password was correct (valid with the strobe) |
| attempt_is_cfg | input | 1 | Attempted operation is a configuration operation |
| cfg_q | output | 8 | Policy byte read value |
| limit_q | output | 8 | Limit read value |
| count_q | output | 8 | Counter read value |
| normal_allowed | output | 1 | Normal read/write operations are permitted |
| config_allowed | output | 1 | Configuration operations are permitted |

## Verification
The bench drives the counter up to the limit and checks which lockout style applies for all four select codes. It checks that a lock with select 1,0 also closes configuration, where a design that decoded the selects the wrong way round would leave configuration open. It loads the counter above the limit to check the wrap through 255 to 0, which a saturating counter would fail. It places a counter write in the same cycle as an attempt strobe to check which one wins. It makes wrong configuration attempts during a configuration-only lock, where a design without the freeze at the lockout point would step past the limit and reopen normal access.

// File: rtl/pw_retry_pkg.sv
package pw_retry_pkg;
  localparam int CNT_W   = 8;
  localparam int CFG_W   = 8;
  localparam int SELA_BIT = 7;
  localparam int SELB_BIT = 6;
  localparam int CLR_BIT  = 3;
  localparam int ENA_BIT  = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic sel_a;
    logic sel_b;
    logic clr_on_ok;
    logic cnt_en;
  } guard_cfg_t;

  function automatic guard_cfg_t cfg_unpack(input logic [CFG_W-1:0] b);
    guard_cfg_t c;
    c.sel_a     = b[SELA_BIT];
    c.sel_b     = b[SELB_BIT];
    c.clr_on_ok = b[CLR_BIT];
    c.cnt_en    = b[ENA_BIT];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input guard_cfg_t c);
    logic [CFG_W-1:0] b;
    b = '0;
    b[SELA_BIT] = c.sel_a;
    b[SELB_BIT] = c.sel_b;
    b[CLR_BIT]  = c.clr_on_ok;
    b[ENA_BIT]  = c.cnt_en;
    return b;
  endfunction

  // Lockout point: counting active and counter has met the limit.
  function automatic logic limit_hit(input guard_cfg_t c, input cnt_t cnt, input cnt_t lim);
    return c.cnt_en && (cnt == lim);
  endfunction

  // Total lockout style: select A set, select B clear.
  function automatic logic total_lock_style(input guard_cfg_t c);
    return c.sel_a && !c.sel_b;
  endfunction

  // Counter value after one finished attempt.
  function automatic cnt_t next_count(input guard_cfg_t c, input cnt_t cnt,
                                      input logic ok, input logic class_ok,
                                      input logic at_lim);
    if (!c.cnt_en || !class_ok) return cnt;
    if (ok)                     return c.clr_on_ok ? cnt_t'(0) : cnt;
    if (at_lim)                 return cnt;
    return cnt + cnt_t'(1);
  endfunction
endpackage

// File: rtl/pw_retry_cfg_reg.sv
module pw_retry_cfg_reg
  import pw_retry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output guard_cfg_t       cfg,
  output logic [CFG_W-1:0] rd_data
);
  guard_cfg_t cfg_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_r <= '0;
    else if (wr_en) cfg_r <= cfg_unpack(wr_data);
  end

  assign cfg     = cfg_r;
  assign rd_data = cfg_pack(cfg_r);
endmodule

// File: rtl/pw_retry_policy.sv
module pw_retry_policy
  import pw_retry_pkg::*;
(
  input  guard_cfg_t cfg,
  input  cnt_t       count,
  input  cnt_t       limit,
  input  logic       is_cfg_op,
  output logic       at_limit,
  output logic       normal_ok,
  output logic       config_ok,
  output logic       class_ok
);
  always_comb begin
    at_limit  = limit_hit(cfg, count, limit);
    normal_ok = !at_limit;
    config_ok = !(at_limit && total_lock_style(cfg));
    class_ok  = is_cfg_op ? config_ok : normal_ok;
  end
endmodule

// File: rtl/pw_retry_counter.sv
module pw_retry_counter
  import pw_retry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  guard_cfg_t cfg,
  input  logic       lim_wr_en,
  input  cnt_t       lim_wr_data,
  input  logic       cnt_wr_en,
  input  cnt_t       cnt_wr_data,
  input  logic       attempt_done,
  input  logic       attempt_ok,
  input  logic       class_ok,
  input  logic       at_limit,
  output cnt_t       count,
  output cnt_t       limit
);
  cnt_t count_r, limit_r, count_upd;

  assign count_upd = next_count(cfg, count_r, attempt_ok, class_ok, at_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_r <= '0;
      limit_r <= '0;
    end else begin
      if (lim_wr_en)         limit_r <= lim_wr_data;
      if (cnt_wr_en)         count_r <= cnt_wr_data;
      else if (attempt_done) count_r <= count_upd;
    end
  end

  assign count = count_r;
  assign limit = limit_r;
endmodule

// File: rtl/pw_retry_guard.sv
module pw_retry_guard
  import pw_retry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  input  logic             lim_wr_en,
  input  logic [CNT_W-1:0] lim_wr_data,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             attempt_done,
  input  logic             attempt_ok,
  input  logic             attempt_is_cfg,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CNT_W-1:0] limit_q,
  output logic [CNT_W-1:0] count_q,
  output logic             normal_allowed,
  output logic             config_allowed
);
  guard_cfg_t cfg;
  cnt_t       count, limit;
  logic       at_limit, class_ok, normal_ok, config_ok;

  pw_retry_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg(cfg), .rd_data(cfg_q)
  );

  pw_retry_policy u_pol (
    .cfg(cfg), .count(count), .limit(limit), .is_cfg_op(attempt_is_cfg),
    .at_limit(at_limit), .normal_ok(normal_ok), .config_ok(config_ok),
    .class_ok(class_ok)
  );

  pw_retry_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .attempt_done(attempt_done), .attempt_ok(attempt_ok),
    .class_ok(class_ok), .at_limit(at_limit),
    .count(count), .limit(limit)
  );

  assign count_q        = count;
  assign limit_q        = limit;
  assign normal_allowed = normal_ok;
  assign config_allowed = config_ok;
endmodule

// File: rtl/pw_retry_guard_chk.sv
module pw_retry_guard_chk
  import pw_retry_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             attempt_done,
  input logic             attempt_ok,
  input logic             cnt_wr_en,
  input logic [CFG_W-1:0] cfg_q,
  input logic [CNT_W-1:0] limit_q,
  input logic [CNT_W-1:0] count_q,
  input logic             normal_allowed,
  input logic             config_allowed,
  input logic             class_ok,
  input logic             at_limit
);
  wire en  = cfg_q[ENA_BIT];
  wire clr = cfg_q[CLR_BIT];
  wire sa  = cfg_q[SELA_BIT];
  wire sb  = cfg_q[SELB_BIT];

  // R4
  off_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (normal_allowed && config_allowed));

  // R5
  below_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count_q != limit_q) |-> (normal_allowed && config_allowed));

  // R6
  total_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count_q == limit_q && sa && !sb) |-> (!normal_allowed && !config_allowed));

  // R7
  cfg_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    normal_allowed |-> config_allowed);

  // R8
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_done && !cnt_wr_en && en && !attempt_ok && class_ok && !at_limit)
    |=> count_q == CNT_W'($past(count_q) + 1'b1));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_done && !cnt_wr_en && en && attempt_ok && clr && class_ok) |=> count_q == '0);

  // R10
  denied_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_done && !cnt_wr_en && !class_ok) |=> $stable(count_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!attempt_done && !cnt_wr_en) |=> $stable(count_q));
endmodule

bind pw_retry_guard pw_retry_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .attempt_done(attempt_done), .attempt_ok(attempt_ok),
  .cnt_wr_en(cnt_wr_en), .cfg_q(cfg_q), .limit_q(limit_q), .count_q(count_q),
  .normal_allowed(normal_allowed), .config_allowed(config_allowed),
  .class_ok(class_ok), .at_limit(at_limit)
);

// File: tb/pw_retry_guard_tb.sv
module pw_retry_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0, lim_wr_en = 0, cnt_wr_en = 0;
  logic [7:0] cfg_wr_data = 0, lim_wr_data = 0, cnt_wr_data = 0;
  logic attempt_done = 0, attempt_ok = 0, attempt_is_cfg = 0;
  logic [7:0] cfg_q, limit_q, count_q;
  logic normal_allowed, config_allowed;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] m_cfg = 0, m_lim = 0, m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_retry_guard dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .lim_wr_en(lim_wr_en), .lim_wr_data(lim_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .attempt_done(attempt_done), .attempt_ok(attempt_ok),
    .attempt_is_cfg(attempt_is_cfg),
    .cfg_q(cfg_q), .limit_q(limit_q), .count_q(count_q),
    .normal_allowed(normal_allowed), .config_allowed(config_allowed)
  );

  function automatic bit m_locked(input logic [7:0] c, input logic [7:0] n, input logic [7:0] l);
    return c[2] && (n == l);
  endfunction
  function automatic bit m_norm(input logic [7:0] c, input logic [7:0] n, input logic [7:0] l);
    return !m_locked(c, n, l);
  endfunction
  function automatic bit m_conf(input logic [7:0] c, input logic [7:0] n, input logic [7:0] l);
    return !(m_locked(c, n, l) && c[7:6] == 2'b10);
  endfunction
  function automatic logic [7:0] m_next(input logic [7:0] c, input logic [7:0] n,
      input logic [7:0] l, input bit nw, input logic [7:0] nd,
      input bit ad, input bit ok, input bit isc);
    bit perm;
    if (nw) return nd;
    if (!ad || !c[2]) return n;
    perm = isc ? m_conf(c, n, l) : m_norm(c, n, l);
    if (!perm) return n;
    if (ok) return c[3] ? 8'd0 : n;
    if (n == l) return n;
    return n + 8'd1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 policy readback", cfg_q, m_cfg);
    chk("R3 limit readback", limit_q, m_lim);
    chk("R8 counter", count_q, m_cnt);
    chk("R6 normal_allowed", normal_allowed, m_norm(m_cfg, m_cnt, m_lim));
    chk("R7 config_allowed", config_allowed, m_conf(m_cfg, m_cnt, m_lim));
  endtask

  // one clock: drive at negedge, check at the following negedge
  task automatic cyc(input bit cw, input logic [7:0] cd, input bit lw, input logic [7:0] ld,
                     input bit nw, input logic [7:0] nd, input bit ad, input bit ok, input bit isc);
    logic [7:0] n_cfg, n_lim, n_cnt;
    cfg_wr_en = cw; cfg_wr_data = cd; lim_wr_en = lw; lim_wr_data = ld;
    cnt_wr_en = nw; cnt_wr_data = nd;
    attempt_done = ad; attempt_ok = ok; attempt_is_cfg = isc;
    n_cnt = m_next(m_cfg, m_cnt, m_lim, nw, nd, ad, ok, isc);
    n_cfg = cw ? (cd & 8'hCC) : m_cfg;
    n_lim = lw ? ld : m_lim;
    @(posedge clk);
    @(negedge clk);
    m_cfg = n_cfg; m_lim = n_lim; m_cnt = n_cnt;
    cfg_wr_en = 0; lim_wr_en = 0; cnt_wr_en = 0; attempt_done = 0;
    check_all();
  endtask

  task automatic idle();        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wcfg(input logic [7:0] d); cyc(1, d, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wlim(input logic [7:0] d); cyc(0, 0, 1, d, 0, 0, 0, 0, 0); endtask
  task automatic wcnt(input logic [7:0] d); cyc(0, 0, 0, 0, 1, d, 0, 0, 0); endtask
  task automatic att(input bit ok, input bit isc); cyc(0, 0, 0, 0, 0, 0, 1, ok, isc); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count_q, 0); chk("R1 limit", limit_q, 0); chk("R1 cfg", cfg_q, 0);
    chk("R1 normal", normal_allowed, 1); chk("R1 config", config_allowed, 1);
    rst_n = 1;
    @(negedge clk);
    idle();

    // R2 reserved bits read as zero
    wcfg(8'hFF); chk("R2 reserved bits", cfg_q, 8'hCC);
    wcfg(8'h33); chk("R2 reserved bits", cfg_q, 8'h00);

    // R4 counting disabled: no lock, attempts do nothing
    wlim(8'd7); wcnt(8'd7);
    chk("R4 normal open", normal_allowed, 1);
    att(0, 0); chk("R4 counter held", count_q, 7);

    // R3 counter write beats same-cycle attempt
    wcfg(8'h04); wcnt(8'd2);
    cyc(0, 0, 0, 0, 1, 8'd200, 1, 0, 0); chk("R3 write priority", count_q, 200);

    // R8 wrap from 255 to 0
    wlim(8'd5); wcnt(8'd255);
    att(0, 0); chk("R8 wrap", count_q, 0);
    chk("R5 open below limit", normal_allowed, 1);

    // R6 total lock with select 1,0
    wcfg(8'h84); wlim(8'd2); wcnt(8'd1);
    att(0, 0); chk("R6 count at limit", count_q, 2);
    chk("R6 normal closed", normal_allowed, 0); chk("R6 config closed", config_allowed, 0);
    att(1, 1); chk("R10 forbidden class ignored", count_q, 2);

    // R7 configuration-only lock, other select codes
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        wcfg({s[1:0], 6'b000100});
        chk("R7 normal closed", normal_allowed, 0);
        chk("R7 config open", config_allowed, 1);
        att(0, 1); chk("R10 frozen at limit", count_q, 2);
        att(1, 0); chk("R10 normal attempt ignored", count_q, 2);
      end
    end

    // R9 clear-on-success and keep
    wcfg(8'h0C); att(1, 1); chk("R9 cleared", count_q, 0);
    wcfg(8'h04); att(0, 0); att(1, 0); chk("R9 kept", count_q, 1);

    // R11 idle holds
    repeat (3) idle(); chk("R11 hold", count_q, 1);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 16;
      case (r)
        0: wcfg(($urandom % 4 == 0) ? 8'($urandom) : (8'($urandom) | 8'h04));
        1: wlim(($urandom % 8 == 0) ? 8'd255 : 8'($urandom % 4));
        2: wcnt(($urandom % 8 == 0) ? 8'(250 + $urandom % 6) : 8'($urandom % 4));
        3: cyc(0, 0, 0, 0, 1, 8'($urandom % 4), 1, $urandom % 2, $urandom % 2);
        4: idle();
        default: att(($urandom % 3) == 0, $urandom % 2);
      endcase
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule